// File: doc/BRIEF.md
# Floating-Point to Signed 32-Bit Integer Converter

This block turns an already unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent and a significand whose top bit is the leading integer bit, plus a separate sticky bit for anything already lost below the significand. The conversion always truncates toward zero, whatever rounding mode the rest of the datapath uses. The block reports an inexact flag when discarded bits were nonzero and an invalid-operation flag when the value cannot be represented.

Values that are too large, and all infinities and NaNs, saturate to a sign-dependent code. The range check is asymmetric: the most negative integer is reachable, its positive twin is not. On saturation the inexact indication is dropped and only invalid is raised. There is no underflow indication: tiny values quietly become zero with inexact set.

The result is registered: an operand presented with `valid_i` high appears on the outputs one clock later, and the outputs hold between operands.

Top module: `f2i_conv`

## Requirements
- R1: The outputs are registered. `valid_o` equals `valid_i` one cycle later, and `result_o`, `inexact_o` and `invalid_o` update only in the cycle after `valid_i` was high, otherwise they keep their values.
- R2: Class code 0 (zero) returns 0 with both flags low, whatever the sign, significand and sticky inputs.
- R3: A class 1 (number) operand whose exponent, read as a signed 16-bit value, is 32 or more is an overflow.
- R4: For class 1 with exponent below 32, the operand value is sig_i[SIG_W-1].sig_i[SIG_W-2:0] times 2 to the exponent; the integer magnitude is this value truncated toward zero, and an exponent below zero gives magnitude 0.
- R5: For an in-range class 1 result, `inexact_o` is 1 exactly when a discarded significand bit or `sticky_i` was 1.
- R6: Let M be the truncated magnitude; class 1 overflows when M is at least 0x80000000 plus the sign bit. A positive M of 0x80000000 overflows; a negative one returns 0x80000000 without invalid.
- R7: A negative in-range result is the two's-complement negation of M; a positive one is M.
- R8: Class codes 2 (infinity) and 3 (NaN) always overflow.
- R9: On overflow `invalid_o` is 1, `inexact_o` is 0 and `result_o` is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.
- R10: While `rst_ni` is low, `valid_o`, `result_o`, `inexact_o` and `invalid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| class_i | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| sign_i | input | 1 | Operand sign, 1 is negative |
| exp_i | input | 16 | Signed unbiased exponent of the leading bit |
| sig_i | input | SIG_W | Significand, leading integer bit at the top |
| sticky_i | input | 1 | OR of bits already lost below the significand |
| valid_o | output | 1 | Result present |
| result_o | output | 32 | Two's-complement integer |
| inexact_o | output | 1 | Nonzero bits were discarded |
| invalid_o | output | 1 | Overflow, infinity or NaN |

## Verification
The assertions check on every cycle the one-cycle latency and output hold, the zero-class result, forced overflow for large exponents and for infinities and NaNs, the legal saturation codes and their sign dependence, the exclusion of inexact and invalid, and that the result sign follows the operand sign. Only the bench scenarios can show the exact truncated magnitudes, the inexact flag from discarded fraction and sticky bits, negative-exponent values, and the asymmetric edge around 0x80000000 with and without a fraction.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int INT_W = 32;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } op_class_e;
endpackage

// File: rtl/f2i_rshift_sticky.sv
// Logarithmic right shifter that ORs every bit shifted out into a sticky flag.
module f2i_rshift_sticky #(
  parameter int W    = 40,
  parameter int SH_W = 6
) (
  input  logic [W-1:0]    data_i,
  input  logic            sticky_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    data_o,
  output logic            sticky_o
);
  logic [W-1:0] stage_d [0:SH_W];
  logic         stage_s [0:SH_W];

  assign stage_d[0] = data_i;
  assign stage_s[0] = sticky_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH < W) begin : g_part
      assign stage_d[k+1] = amt_i[k] ? (stage_d[k] >> SH) : stage_d[k];
      assign stage_s[k+1] = stage_s[k] | (amt_i[k] & (|stage_d[k][SH-1:0]));
    end else begin : g_full
      assign stage_d[k+1] = amt_i[k] ? '0 : stage_d[k];
      assign stage_s[k+1] = stage_s[k] | (amt_i[k] & (|stage_d[k]));
    end
  end

  assign data_o   = stage_d[SH_W];
  assign sticky_o = stage_s[SH_W];
endmodule

// File: rtl/f2i_align.sv
// Places the integer part of the operand in the low INT_W bits.
module f2i_align
  import f2i_pkg::*;
#(
  parameter int SIG_W = 40
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic             sticky_i,
  input  logic [15:0]      exp_i,
  output logic [INT_W-1:0] mag_o,
  output logic             lost_o,
  output logic             big_o,
  output logic             hi_nz_o
);
  localparam int SH_W = $clog2(SIG_W + 1);

  logic [SH_W-1:0]  amt;
  logic [SIG_W-1:0] shifted;
  int               e;

  always_comb begin
    e     = int'($signed(exp_i));
    big_o = (e >= INT_W);
    if (e < 0)          amt = SH_W'(SIG_W);
    else if (e >= INT_W) amt = '0;
    else                 amt = SH_W'(SIG_W - 1 - e);
  end

  f2i_rshift_sticky #(.W(SIG_W), .SH_W(SH_W)) u_shift (
    .data_i  (sig_i),
    .sticky_i(sticky_i),
    .amt_i   (amt),
    .data_o  (shifted),
    .sticky_o(lost_o)
  );

  assign mag_o   = shifted[INT_W-1:0];
  // defensive: any bit left above the integer field means overflow
  assign hi_nz_o = |shifted[SIG_W-1:INT_W];
endmodule

// File: rtl/f2i_saturate.sv
module f2i_saturate
  import f2i_pkg::*;
(
  input  op_class_e        cls_i,
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             lost_i,
  input  logic             big_i,
  input  logic             hi_nz_i,
  output logic [INT_W-1:0] result_o,
  output logic             inexact_o,
  output logic             invalid_o
);
  localparam logic [INT_W:0] MIN_MAG = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};

  logic [INT_W:0] limit;
  logic           num, ovf;

  always_comb begin
    limit = MIN_MAG + (INT_W+1)'(sign_i);
    num   = (cls_i == CLS_NUM);
    ovf   = (cls_i == CLS_INF) || (cls_i == CLS_NAN) ||
            (num && (big_i || hi_nz_i || ({1'b0, mag_i} >= limit)));
    if (ovf)       result_o = POS_SAT + INT_W'(sign_i);
    else if (!num) result_o = '0;
    else           result_o = sign_i ? (~mag_i + 1'b1) : mag_i;
    inexact_o = num && !ovf && lost_i;
    invalid_o = ovf;
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int SIG_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       class_i,
  input  logic             sign_i,
  input  logic [15:0]      exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             sticky_i,
  output logic             valid_o,
  output logic [31:0]      result_o,
  output logic             inexact_o,
  output logic             invalid_o
);
  logic [INT_W-1:0] mag, res_d;
  logic             lost, big, hi_nz, inx_d, inv_d;

  f2i_align #(.SIG_W(SIG_W)) u_align (
    .sig_i   (sig_i),
    .sticky_i(sticky_i),
    .exp_i   (exp_i),
    .mag_o   (mag),
    .lost_o  (lost),
    .big_o   (big),
    .hi_nz_o (hi_nz)
  );

  f2i_saturate u_sat (
    .cls_i    (op_class_e'(class_i)),
    .sign_i   (sign_i),
    .mag_i    (mag),
    .lost_i   (lost),
    .big_i    (big),
    .hi_nz_i  (hi_nz),
    .result_o (res_d),
    .inexact_o(inx_d),
    .invalid_o(inv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        inexact_o <= inx_d;
        invalid_o <= inv_d;
      end
    end
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int SIG_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       class_i,
  input logic             sign_i,
  input logic [15:0]      exp_i,
  input logic [SIG_W-1:0] sig_i,
  input logic             sticky_i,
  input logic             valid_o,
  input logic [31:0]      result_o,
  input logic             inexact_o,
  input logic             invalid_o
);
  assert_valid_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(inexact_o) && $stable(invalid_o)));
  assert_zero_class_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 2'd0) |=> (result_o == 32'd0 && !inexact_o && !invalid_o));
  assert_big_exp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 2'd1 && $signed(exp_i) >= 32) |=> invalid_o);
  assert_pos_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 2'd1 && !sign_i) |=> !result_o[31]);
  assert_neg_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 2'd1 && sign_i) |=> (result_o == 32'd0 || result_o[31]));
  assert_special_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i[1]) |=> invalid_o);
  assert_flag_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inexact_o && invalid_o));
  assert_sat_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (result_o == 32'h7FFF_FFFF || result_o == 32'h8000_0000));
  assert_sat_neg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i[1] && sign_i) |=> result_o == 32'h8000_0000);
  assert_sat_pos_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i[1] && !sign_i) |=> result_o == 32'h7FFF_FFFF);
endmodule

bind f2i_conv f2i_conv_chk #(.SIG_W(SIG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .class_i  (class_i),
  .sign_i   (sign_i),
  .exp_i    (exp_i),
  .sig_i    (sig_i),
  .sticky_i (sticky_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .inexact_o(inexact_o),
  .invalid_o(invalid_o)
);

// File: tb/f2i_conv_test.sv
`timescale 1ns/1ps
module f2i_conv_test;
  localparam int SW = 40;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    class_i = 2'd0;
  logic          sign_i = 1'b0;
  logic [15:0]   exp_i = '0;
  logic [SW-1:0] sig_i = '0;
  logic          sticky_i = 1'b0;
  logic          valid_o;
  logic [31:0]   result_o;
  logic          inexact_o, invalid_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk_i = ~clk_i;

  f2i_conv #(.SIG_W(SW)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // Drive one operand, then compare all outputs after the capturing edge.
  task automatic run(string req, logic [1:0] cls, logic sgn, int e,
                     logic [SW-1:0] sig, logic stk,
                     logic [31:0] exp_res, logic exp_inx, logic exp_inv);
    @(negedge clk_i);
    valid_i = 1'b1; class_i = cls; sign_i = sgn;
    exp_i = 16'(e); sig_i = sig; sticky_i = stk;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " valid"},   32'(valid_o),   32'd1);
    check({req, " result"},  result_o,       exp_res);
    check({req, " inexact"}, 32'(inexact_o), 32'(exp_inx));
    check({req, " invalid"}, 32'(invalid_o), 32'(exp_inv));
  endtask

  task automatic test_reset;
    check("R10 valid",   32'(valid_o),   32'd0);
    check("R10 result",  result_o,       32'd0);
    check("R10 inexact", 32'(inexact_o), 32'd0);
    check("R10 invalid", 32'(invalid_o), 32'd0);
  endtask

  task automatic test_zero;
    run("R2 neg zero", 2'd0, 1'b1, 5, 40'hFF_FFFF_FFFF, 1'b1, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic test_truncate;
    run("R4 five",        2'd1, 1'b0, 2, SW'(5) << 37, 1'b0, 32'd5, 1'b0, 1'b0);
    run("R4 five.75",     2'd1, 1'b0, 2, SW'(23) << 35, 1'b0, 32'd5, 1'b1, 1'b0);
    run("R7 neg five.75", 2'd1, 1'b1, 2, SW'(23) << 35, 1'b0, 32'hFFFF_FFFB, 1'b1, 1'b0);
    run("R7 neg five",    2'd1, 1'b1, 2, SW'(5) << 37, 1'b0, 32'hFFFF_FFFB, 1'b0, 1'b0);
  endtask

  task automatic test_inexact;
    run("R5 sticky only", 2'd1, 1'b0, 2, SW'(7) << 37, 1'b1, 32'd7, 1'b1, 1'b0);
    run("R5 low bit",     2'd1, 1'b0, 0, (SW'(1) << 39) | SW'(1), 1'b0, 32'd1, 1'b1, 1'b0);
  endtask

  task automatic test_neg_exp;
    run("R4 pos 0.75",  2'd1, 1'b0, -1, SW'(3) << 38, 1'b0, 32'd0, 1'b1, 1'b0);
    run("R4 neg 0.75",  2'd1, 1'b1, -1, SW'(3) << 38, 1'b0, 32'd0, 1'b1, 1'b0);
    run("R4 min exp",   2'd1, 1'b0, -32768, SW'(1) << 39, 1'b0, 32'd0, 1'b1, 1'b0);
  endtask

  task automatic test_edge;
    run("R6 pos 2^31",      2'd1, 1'b0, 31, SW'(1) << 39, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1);
    run("R6 neg 2^31",      2'd1, 1'b1, 31, SW'(1) << 39, 1'b0, 32'h8000_0000, 1'b0, 1'b0);
    run("R6 neg 2^31+0.5",  2'd1, 1'b1, 31, (SW'(1) << 39) | (SW'(1) << 7), 1'b0,
        32'h8000_0000, 1'b1, 1'b0);
    run("R6 neg 2^31+1",    2'd1, 1'b1, 31, (SW'(1) << 39) | (SW'(1) << 8), 1'b0,
        32'h8000_0000, 1'b0, 1'b1);
    run("R6 pos 2^31-0.5",  2'd1, 1'b0, 30, 40'hFF_FFFF_FF00, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic test_overflow;
    run("R3 exp 32",     2'd1, 1'b0, 32, SW'(1) << 39, 1'b1, 32'h7FFF_FFFF, 1'b0, 1'b1);
    run("R3 max exp",    2'd1, 1'b1, 32767, SW'(3) << 38, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
    run("R8 pos inf",    2'd2, 1'b0, 0, '0, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1);
    run("R8 neg inf",    2'd2, 1'b1, 0, '0, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
    run("R9 nan sticky", 2'd3, 1'b0, 3, 40'hC0_0000_0001, 1'b1, 32'h7FFF_FFFF, 1'b0, 1'b1);
  endtask

  task automatic test_hold;
    run("R1 load", 2'd1, 1'b0, 4, SW'(19) << 35, 1'b0, 32'd19, 1'b0, 1'b0);
    @(negedge clk_i);
    class_i = 2'd2; sign_i = 1'b1; exp_i = 16'd40; sticky_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle valid",   32'(valid_o),   32'd0);
    check("R1 hold result",  result_o,       32'd19);
    check("R1 hold inexact", 32'(inexact_o), 32'd0);
    check("R1 hold invalid", 32'(invalid_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    test_zero();
    test_truncate();
    test_inexact();
    test_neg_exp();
    test_edge();
    test_overflow();
    test_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule